// File: doc/BRIEF.md
# Set-Associative Flow Digest Cache

This block is a small classification cache for a packet pipeline. Its ways do not hold the full flow key. Each way holds a short hashed digest of the key and a few bits of classification result, such as an egress interface number. A lookup takes a flow key and folds it into two hashes: one picks the set and the other forms the digest. All ways of that set are compared in the same cycle. A match returns the stored result and the way that held it.

On a miss, the surrounding pipeline has the packet classified by its full classifier. It then writes the flow key and result back through the insert port. The block places the entry in a free way if one exists, otherwise in the least recently used way. A start-of-connection hint on the lookup port makes the block report a miss, so that new connections always go through full classification.

Because only digests are kept, two different flows that land in the same set with the same digest are treated as one flow. The chance of this is roughly the number of ways divided by two to the power of the digest width. Storage per entry is the digest width plus the result width plus a valid bit and two age bits.

Top module: `flow_digest_cache`

## Requirements
- R1: After reset every way is empty, so any lookup without a prior insert reports a miss.
- R2: An accepted lookup (lookup valid and ready both high at a clock edge) raises the response valid for exactly the following cycle. With no accepted lookup, response valid stays low.
- R3: The set index is the XOR fold of the key into SET_W bits: key bit i goes to index bit i mod SET_W. The digest is the XOR fold of the key into DIG_W bits in the same way. A lookup hits when a valid way of the indexed set holds the lookup's digest. The response then gives the stored result and that way's number; if several ways match, the lowest-numbered one is used.
- R4: On a miss, the response result and way fields are both zero.
- R5: A lookup with the start-of-connection hint high reports a miss even if a way matches. It does not change the recency order.
- R6: An insert whose digest is not present in its set fills the lowest-numbered empty way of that set.
- R7: When all ways of a set are valid, an insert with a new digest replaces the least recently used way. Non-hinted hits and inserts both count as use.
- R8: An insert whose digest already sits in a valid way of its set overwrites the result of that way and creates no second copy.
- R9: Two different keys with equal set index and equal digest are treated as the same flow. A lookup of one hits on the entry inserted for the other.
- R10: The insert port is always ready. An insert takes priority, so lookup ready is low in any cycle in which insert valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request valid |
| lkReady | output | 1 | Lookup request accepted this cycle |
| lkFlow | input | KEY_W | Flow key to look up |
| lkSyn | input | 1 | Start-of-connection hint; forces a miss |
| rspValid | output | 1 | Lookup response valid |
| rspHit | output | 1 | Lookup hit |
| rspResult | output | RES_W | Stored result on a hit, zero on a miss |
| rspWay | output | WAY_W | Matching way on a hit, zero on a miss |
| insValid | input | 1 | Insert request valid |
| insReady | output | 1 | Insert request accepted (always high) |
| insFlow | input | KEY_W | Flow key to insert |
| insResult | input | RES_W | Classification result to store |

## Verification
The assertions assume that the response is consumed in the cycle it appears, since it has no back-pressure. They also assume that the requester holds a lookup until lkReady is high. The stimulus issues one request at a time and releases it after the accepting edge. Inserts are issued only when no lookup is pending, so every lookup it drives is accepted. Keys in the random phase come from a small pool confined to a few sets, which makes evictions, refills and re-inserts frequent while the model's recency order stays comparable to the block's.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  typedef struct packed {
    logic lookupEn;
    logic insertEn;
    logic forceMiss;
  } fdc_strobe_t;
endpackage

// File: rtl/fdc_ctrl.sv
module fdc_ctrl
  import fdc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lkValid,
  input  logic        lkSyn,
  input  logic        insValid,
  output logic        lkReady,
  output logic        insReady,
  output logic        rspValid,
  output fdc_strobe_t strb
);
  // inserts win the single array port; lookups wait
  always_comb begin
    insReady       = 1'b1;
    lkReady        = ~insValid;
    strb.insertEn  = insValid;
    strb.lookupEn  = lkValid & ~insValid;
    strb.forceMiss = lkSyn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= strb.lookupEn;
  end

  a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkReady) |=> rspValid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !(lkValid && lkReady) |=> !rspValid);
  a_r10_insert_priority: assert property (@(posedge clk) disable iff (!rstN)
    insValid |-> !lkReady);
endmodule

// File: rtl/fdc_datapath.sv
module fdc_datapath
  import fdc_pkg::*;
#(
  parameter int KEY_W = 64,
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int DIG_W = 32,
  parameter int RES_W = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fdc_strobe_t      strb,
  input  logic [KEY_W-1:0] lkFlow,
  input  logic [KEY_W-1:0] insFlow,
  input  logic [RES_W-1:0] insResult,
  output logic             rspHit,
  output logic [RES_W-1:0] rspResult,
  output logic [WAY_W-1:0] rspWay
);
  localparam int AGE_SUM = WAYS * (WAYS - 1) / 2;

  logic [DIG_W-1:0] dgstMem  [SETS][WAYS];
  logic [RES_W-1:0] resMem   [SETS][WAYS];
  logic             validMem [SETS][WAYS];
  logic [AGE_W-1:0] ageMem   [SETS][WAYS];

  logic [KEY_W-1:0] opKey;
  logic [SET_W-1:0] setIdx;
  logic [DIG_W-1:0] opDig;
  logic [WAYS-1:0]  matchVec, freeVec;
  logic             hitAny, freeAny, touchEn;
  logic [WAY_W-1:0] hitWay, freeWay, lruWay, insWay, touchWay;
  logic [AGE_W-1:0] curAge [WAYS];
  logic [AGE_W-1:0] newAge [WAYS];

  // two independent folds of the key
  always_comb begin
    opKey  = strb.insertEn ? insFlow : lkFlow;
    setIdx = '0;
    opDig  = '0;
    for (int i = 0; i < KEY_W; i++) begin
      setIdx[i % SET_W] = setIdx[i % SET_W] ^ opKey[i];
      opDig[i % DIG_W]  = opDig[i % DIG_W]  ^ opKey[i];
    end
  end

  // compare every way of the set at once; pick hit, free and victim ways
  always_comb begin
    hitAny  = 1'b0;
    freeAny = 1'b0;
    hitWay  = '0;
    freeWay = '0;
    lruWay  = '0;
    for (int w = 0; w < WAYS; w++) begin
      matchVec[w] = validMem[setIdx][w] && (dgstMem[setIdx][w] == opDig);
      freeVec[w]  = ~validMem[setIdx][w];
      curAge[w]   = ageMem[setIdx][w];
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) begin hitAny = 1'b1;  hitWay  = WAY_W'(w); end
      if (freeVec[w])  begin freeAny = 1'b1; freeWay = WAY_W'(w); end
      if (curAge[w] == AGE_W'(WAYS - 1)) lruWay = WAY_W'(w);
    end
    insWay   = hitAny ? hitWay : (freeAny ? freeWay : lruWay);
    touchEn  = strb.insertEn | (strb.lookupEn & hitAny & ~strb.forceMiss);
    touchWay = strb.insertEn ? insWay : hitWay;
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touchWay)            newAge[w] = '0;
      else if (curAge[w] < curAge[touchWay]) newAge[w] = curAge[w] + 1'b1;
      else                                   newAge[w] = curAge[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          validMem[s][w] <= 1'b0;
          ageMem[s][w]   <= AGE_W'(w);
        end
    end else begin
      if (touchEn)
        for (int w = 0; w < WAYS; w++) ageMem[setIdx][w] <= newAge[w];
      if (strb.insertEn) validMem[setIdx][insWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.insertEn) begin
      dgstMem[setIdx][insWay] <= opDig;
      resMem[setIdx][insWay]  <= insResult;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strb.lookupEn || !hitAny || strb.forceMiss) begin
      rspHit    <= 1'b0;
      rspResult <= '0;
      rspWay    <= '0;
    end else begin
      rspHit    <= 1'b1;
      rspResult <= resMem[setIdx][hitWay];
      rspWay    <= hitWay;
    end
  end

  a_r5_hint_forces_miss: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lookupEn && strb.forceMiss) |=> !rspHit);
  a_r4_miss_fields_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> (rspResult == '0 && rspWay == '0));

  // R7: ages of each set stay a permutation of 0..WAYS-1
  logic [AGE_W+7:0] ageSum [SETS];
  always_comb
    for (int s = 0; s < SETS; s++) begin
      ageSum[s] = '0;
      for (int w = 0; w < WAYS; w++) ageSum[s] = ageSum[s] + (AGE_W+8)'(ageMem[s][w]);
    end
  for (genvar s = 0; s < SETS; s++) begin : g_ageChk
    a_r7_age_perm: assert property (@(posedge clk) disable iff (!rstN)
      ageSum[s] == (AGE_W+8)'(AGE_SUM));
  end
endmodule

// File: rtl/flow_digest_cache.sv
module flow_digest_cache
  import fdc_pkg::*;
#(
  parameter int KEY_W = 64,
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int DIG_W = 32,
  parameter int RES_W = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  output logic             lkReady,
  input  logic [KEY_W-1:0] lkFlow,
  input  logic             lkSyn,
  output logic             rspValid,
  output logic             rspHit,
  output logic [RES_W-1:0] rspResult,
  output logic [WAY_W-1:0] rspWay,
  input  logic             insValid,
  output logic             insReady,
  input  logic [KEY_W-1:0] insFlow,
  input  logic [RES_W-1:0] insResult
);
  fdc_strobe_t strb;

  fdc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkSyn(lkSyn),
    .insValid(insValid), .lkReady(lkReady), .insReady(insReady),
    .rspValid(rspValid), .strb(strb)
  );

  fdc_datapath #(.KEY_W(KEY_W), .SETS(SETS), .WAYS(WAYS), .DIG_W(DIG_W), .RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lkFlow(lkFlow), .insFlow(insFlow),
    .insResult(insResult), .rspHit(rspHit), .rspResult(rspResult), .rspWay(rspWay)
  );
endmodule

// File: tb/flow_digest_cache_bench.sv
module flow_digest_cache_bench;
  localparam int KEY_W = 64, SETS = 64, WAYS = 4, DIG_W = 32, RES_W = 4;
  localparam int SET_W = 6, WAY_W = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic lkValid = 0, lkSyn = 0, insValid = 0;
  logic [KEY_W-1:0] lkFlow = '0, insFlow = '0;
  logic [RES_W-1:0] insResult = '0;
  logic lkReady, insReady, rspValid, rspHit;
  logic [RES_W-1:0] rspResult;
  logic [WAY_W-1:0] rspWay;

  always #2.5 clk = ~clk;

  flow_digest_cache u_flow_digest_cache (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model
  bit             mValid [SETS][WAYS];
  logic [DIG_W-1:0] mDig [SETS][WAYS];
  logic [RES_W-1:0] mRes [SETS][WAYS];
  int             mAge   [SETS][WAYS];

  function automatic logic [SET_W-1:0] bSet(logic [KEY_W-1:0] k);
    logic [SET_W-1:0] r = '0;
    for (int i = 0; i < KEY_W; i++) r[i % SET_W] ^= k[i];
    return r;
  endfunction
  function automatic logic [DIG_W-1:0] bDig(logic [KEY_W-1:0] k);
    logic [DIG_W-1:0] r = '0;
    for (int i = 0; i < KEY_W; i++) r[i % DIG_W] ^= k[i];
    return r;
  endfunction

  function automatic void mTouch(int s, int w);
    int ref0 = mAge[s][w];
    for (int v = 0; v < WAYS; v++)
      if (mAge[s][v] < ref0) mAge[s][v]++;
    mAge[s][w] = 0;
  endfunction

  function automatic int mFind(logic [KEY_W-1:0] k);
    int s = bSet(k);
    for (int w = 0; w < WAYS; w++)
      if (mValid[s][w] && mDig[s][w] == bDig(k)) return w;
    return -1;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doInsert(logic [KEY_W-1:0] k, logic [RES_W-1:0] r);
    int s, w;
    @(negedge clk);
    insValid = 1; insFlow = k; insResult = r;
    #1;
    check("R10 lkReady low during insert", lkReady, 0);
    check("R10 insReady", insReady, 1);
    @(negedge clk);
    insValid = 0;
    s = bSet(k);
    w = mFind(k);
    if (w < 0) begin
      for (int v = WAYS - 1; v >= 0; v--) if (!mValid[s][v]) w = v;
      if (w < 0) for (int v = 0; v < WAYS; v++) if (mAge[s][v] == WAYS - 1) w = v;
    end
    mValid[s][w] = 1; mDig[s][w] = bDig(k); mRes[s][w] = r;
    mTouch(s, w);
  endtask

  task automatic doLookup(string req, logic [KEY_W-1:0] k, bit syn);
    int w;
    @(negedge clk);
    lkValid = 1; lkFlow = k; lkSyn = syn;
    @(negedge clk);
    lkValid = 0; lkSyn = 0;
    w = syn ? -1 : mFind(k);
    check({req, " rspValid"}, rspValid, 1);
    check({req, " hit"}, rspHit, w >= 0);
    check({req, " result"}, rspResult, w >= 0 ? mRes[bSet(k)][w] : 0);
    check({req, " way"}, rspWay, w >= 0 ? w : 0);
    if (w >= 0) mTouch(bSet(k), w);
  endtask

  function automatic logic [KEY_W-1:0] keyInSet(int s, int salt);
    logic [KEY_W-1:0] k;
    k = {32'(salt) * 32'h9E3779B1, 32'(salt) ^ 32'h5a5a0000};
    // adjust low bits so the set fold equals s
    k[SET_W-1:0] = k[SET_W-1:0] ^ bSet(k) ^ SET_W'(s);
    return k;
  endfunction

  logic [KEY_W-1:0] kA, kB, pool [40];

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7717));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mValid[s][w] = 0; mAge[s][w] = w; end
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check("R2 rspValid idle after reset", rspValid, 0);

    kA = 64'h0123_4567_89ab_cdef;
    doLookup("R1 empty lookup", kA, 0);
    @(negedge clk);
    check("R2 rspValid drops after one cycle", rspValid, 0);

    doInsert(kA, 4'd3);
    doLookup("R3 hit after insert", kA, 0);
    check("R3 result 3", rspResult, 3);
    doLookup("R5 hint forces miss", kA, 1);
    check("R5 hit low", rspHit, 0);

    kB = kA ^ 64'h0000_0015_0000_0015;
    check("R9 same set", bSet(kB), bSet(kA));
    check("R9 same digest", bDig(kB), bDig(kA));
    doLookup("R9 alias hit", kB, 0);
    check("R9 alias result", rspResult, 3);

    // fill one set, then evict LRU
    for (int i = 0; i < 4; i++) doInsert(keyInSet(9, i + 1), RES_W'(i + 8));
    for (int i = 0; i < 4; i++) begin
      doLookup("R6 fill order", keyInSet(9, i + 1), 0);
      check("R6 way order", rspWay, i);
    end
    doLookup("R7 touch way0", keyInSet(9, 1), 0);
    doInsert(keyInSet(9, 5), 4'd1);
    doLookup("R7 evicted misses", keyInSet(9, 2), 0);
    check("R7 oldest gone", rspHit, 0);
    doLookup("R7 new in way1", keyInSet(9, 5), 0);
    check("R7 way1", rspWay, 1);
    doLookup("R5 hint keeps order", keyInSet(9, 3), 1);
    doInsert(keyInSet(9, 6), 4'd2);
    doLookup("R7 after hint", keyInSet(9, 3), 0);
    check("R7 hint did not refresh", rspHit, 0);

    doInsert(keyInSet(9, 4), 4'd14);
    doLookup("R8 overwrite", keyInSet(9, 4), 0);
    check("R8 new result", rspResult, 14);
    check("R8 same way", rspWay, 3);

    for (int i = 0; i < 40; i++) pool[i] = keyInSet(20 + (i % 4), 100 + i);
    for (int n = 0; n < 2500; n++) begin
      int p = $urandom_range(0, 39);
      if ($urandom_range(0, 2) == 0) doInsert(pool[p], RES_W'($urandom));
      else doLookup("R3 R7 random", pool[p], $urandom_range(0, 9) == 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule